// File: doc/BRIEF.md
# DMA Descriptor Configuration Checker

This block guards a DMA channel by checking the transfer descriptor it is about to run and by watching for bus faults while it runs. When a channel is activated, the descriptor's sizes, offsets, destination address, minor-loop byte count and iteration counters are checked together in one cycle. A clean descriptor produces a one-cycle permission pulse that lets the data mover issue its first read. A faulty descriptor withholds that pulse and instead raises a one-cycle error pulse that carries the channel number, so the channel stops.

Two further error sources are folded into the same record. The first is a deferred alignment check on the next-descriptor pointer, which is made only when a major loop completes with descriptor chaining enabled. The second is a bus error reported on a source read or a destination write. The status register keeps only the latest error. A new error overwrites every cause bit and the channel number. Software removes the record by writing one to a clear strobe.

All interfaces are plain control and status pins. Events are single-cycle strobes that are sampled on every clock. The block never exerts back-pressure, so no event can be stalled or lost for lack of a handshake.

Top module: `dma_desc_checker`

## Requirements
- R1: After reset, `go_ok`, `err_valid`, `err_any`, `err_flags` and `err_chan` are all zero.
- R2: Size codes map 0→1, 1→2, 2→4, 3→8 and 4→32 bytes. Flag bit 0 (source offset) is set when `act_soff` is not a multiple of the source size, or when `act_ssize` holds a reserved code (5 to 7).
- R3: Flag bit 1 (destination address) is set when `act_daddr` is not aligned to the destination size, or when `act_dsize` holds a reserved code.
- R4: Flag bit 2 (destination offset) is set when `act_doff` is not a multiple of the destination size.
- R5: Flag bit 3 (count/iteration) is set in any of three cases: `act_nbytes` is not a multiple of both sizes, `act_citer` is zero, or `act_citer_lk` differs from `act_biter_lk`.
- R6: The cycle after an `act_start` whose checks all pass, `go_ok` is high for one cycle. The cycle after an `act_start` whose checks fail, `err_valid` is high for one cycle, `go_ok` stays low, and `err_chan` equals `act_ch`.
- R7: When `mj_done` and `mj_sg_en` are both high and `mj_sga` is not a multiple of 32, flag bit 4 is set. When `mj_sg_en` is low, the pointer is never checked.
- R8: `rd_berr` records flag bit 5 with `rd_ch`. `wr_berr` records flag bit 6 with `wr_ch`.
- R9: Each recorded error replaces all previous cause bits and `err_chan`, and sets `err_any`.
- R10: `err_clr` zeroes `err_flags` and `err_any`. If an error is recorded in the same cycle, the new error wins.
- R11: When several events occur in the same cycle, the activation check takes precedence, then the pointer check, then the read fault, then the write fault. Only the winner is recorded.
- R12: Between recorded errors and clears, `err_flags` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_start | input | 1 | Channel activation strobe |
| act_ch | input | CH_W | Channel being activated |
| act_ssize | input | 3 | Source size code |
| act_dsize | input | 3 | Destination size code |
| act_soff | input | OFF_W | Signed source offset |
| act_daddr | input | ADDR_W | Destination address |
| act_doff | input | OFF_W | Signed destination offset |
| act_nbytes | input | NB_W | Minor-loop byte count |
| act_citer | input | ITER_W | Current major iteration count |
| act_citer_lk | input | 1 | Link enable in current iteration field |
| act_biter_lk | input | 1 | Link enable in beginning iteration field |
| mj_done | input | 1 | Major loop completion strobe |
| mj_ch | input | CH_W | Channel finishing its major loop |
| mj_sg_en | input | 1 | Descriptor chaining enabled |
| mj_sga | input | ADDR_W | Next-descriptor pointer |
| rd_berr | input | 1 | Bus error on source read |
| rd_ch | input | CH_W | Channel of the faulting read |
| wr_berr | input | 1 | Bus error on destination write |
| wr_ch | input | CH_W | Channel of the faulting write |
| err_clr | input | 1 | Write-one-to-clear of the error record |
| go_ok | output | 1 | Activation passed; first read may start |
| err_valid | output | 1 | One-cycle error pulse that stops the channel |
| err_chan | output | CH_W | Channel of the last recorded error |
| err_any | output | 1 | Global error-recorded bit |
| err_flags | output | 7 | Cause bits of the last recorded error |

## Verification
The bench builds the block with NUM_CH=8 and keeps the default 32-bit address and byte-count widths and 16-bit offsets. The narrow channel field lets a few distinct channel numbers show that each event source carries its own channel into `err_chan`. The full-width address and pointer fields reach every size class, including the 32-byte size, with both aligned and misaligned values. Directed cases drive all four event sources in the same cycle and combine clears with new errors, which exercises the precedence and the overwrite rules.

// File: rtl/dma_chk_pkg.sv
package dma_chk_pkg;
  localparam int CAUSE_N  = 7;
  localparam int C_SOFF   = 0;
  localparam int C_DADDR  = 1;
  localparam int C_DOFF   = 2;
  localparam int C_NBITER = 3;
  localparam int C_SGA    = 4;
  localparam int C_RDBUS  = 5;
  localparam int C_WRBUS  = 6;
  localparam int SIZE_W   = 3;
  localparam int MASK_W   = 5;
  localparam logic [MASK_W-1:0] SGA_MASK = 5'h1f;

  typedef logic [CAUSE_N-1:0] cause_t;

  typedef struct packed {
    logic              ok;
    logic [MASK_W-1:0] mask;
  } size_info_t;
endpackage

// File: rtl/dma_size_dec.sv
module dma_size_dec
  import dma_chk_pkg::*;
(
  input  logic [SIZE_W-1:0] code,
  output size_info_t        info
);
  always_comb begin
    info.ok = 1'b1;
    unique case (code)
      3'd0:    info.mask = 5'h00;
      3'd1:    info.mask = 5'h01;
      3'd2:    info.mask = 5'h03;
      3'd3:    info.mask = 5'h07;
      3'd4:    info.mask = 5'h1f;
      default: begin
        info.mask = 5'h00;
        info.ok   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int NB_W   = 32,
  parameter int ITER_W = 15
) (
  input  logic [SIZE_W-1:0] ssize,
  input  logic [SIZE_W-1:0] dsize,
  input  logic [OFF_W-1:0]  soff,
  input  logic [ADDR_W-1:0] daddr,
  input  logic [OFF_W-1:0]  doff,
  input  logic [NB_W-1:0]   nbytes,
  input  logic [ITER_W-1:0] citer,
  input  logic              citer_lk,
  input  logic              biter_lk,
  output cause_t            cause
);
  localparam int SIDES = 2;

  logic [SIDES-1:0][SIZE_W-1:0] codes;
  size_info_t [SIDES-1:0]       infos;

  assign codes[0] = ssize;
  assign codes[1] = dsize;

  for (genvar i = 0; i < SIDES; i++) begin : g_dec
    dma_size_dec u_dec (
      .code (codes[i]),
      .info (infos[i])
    );
  end

  logic [MASK_W-1:0] both_mask;
  assign both_mask = infos[0].mask | infos[1].mask;

  always_comb begin
    cause           = '0;
    cause[C_SOFF]   = !infos[0].ok || (|(soff & OFF_W'(infos[0].mask)));
    cause[C_DADDR]  = !infos[1].ok || (|(daddr & ADDR_W'(infos[1].mask)));
    cause[C_DOFF]   = |(doff & OFF_W'(infos[1].mask));
    cause[C_NBITER] = (|(nbytes & NB_W'(both_mask))) ||
                      (citer == '0) ||
                      (citer_lk != biter_lk);
  end
endmodule

// File: rtl/dma_sg_check.sv
module dma_sg_check
  import dma_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              done,
  input  logic              sg_en,
  input  logic [ADDR_W-1:0] sga,
  output logic              bad
);
  assign bad = done && sg_en && (|(sga & ADDR_W'(SGA_MASK)));
endmodule

// File: rtl/dma_err_rec.sv
module dma_err_rec
  import dma_chk_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  input  cause_t          ev_cause,
  input  logic [CH_W-1:0] ev_ch,
  input  logic            clr,
  output logic            err_valid,
  output logic            err_any,
  output cause_t          err_flags,
  output logic [CH_W-1:0] err_chan
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_any   <= 1'b0;
      err_flags <= '0;
      err_chan  <= '0;
    end else begin
      err_valid <= ev_valid;
      if (ev_valid) begin
        err_any   <= 1'b1;
        err_flags <= ev_cause;
        err_chan  <= ev_ch;
      end else if (clr) begin
        err_any   <= 1'b0;
        err_flags <= '0;
      end
    end
  end
endmodule

// File: rtl/dma_desc_checker.sv
module dma_desc_checker
  import dma_chk_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int NB_W   = 32,
  parameter int ITER_W = 15,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_start,
  input  logic [CH_W-1:0]   act_ch,
  input  logic [2:0]        act_ssize,
  input  logic [2:0]        act_dsize,
  input  logic [OFF_W-1:0]  act_soff,
  input  logic [ADDR_W-1:0] act_daddr,
  input  logic [OFF_W-1:0]  act_doff,
  input  logic [NB_W-1:0]   act_nbytes,
  input  logic [ITER_W-1:0] act_citer,
  input  logic              act_citer_lk,
  input  logic              act_biter_lk,
  input  logic              mj_done,
  input  logic [CH_W-1:0]   mj_ch,
  input  logic              mj_sg_en,
  input  logic [ADDR_W-1:0] mj_sga,
  input  logic              rd_berr,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              wr_berr,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic              err_clr,
  output logic              go_ok,
  output logic              err_valid,
  output logic [CH_W-1:0]   err_chan,
  output logic              err_any,
  output logic [6:0]        err_flags
);
  cause_t cfg_cause;
  logic   cfg_bad;
  logic   sg_bad;

  dma_cfg_check #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .NB_W   (NB_W),
    .ITER_W (ITER_W)
  ) u_cfg (
    .ssize    (act_ssize),
    .dsize    (act_dsize),
    .soff     (act_soff),
    .daddr    (act_daddr),
    .doff     (act_doff),
    .nbytes   (act_nbytes),
    .citer    (act_citer),
    .citer_lk (act_citer_lk),
    .biter_lk (act_biter_lk),
    .cause    (cfg_cause)
  );

  dma_sg_check #(.ADDR_W(ADDR_W)) u_sg (
    .done  (mj_done),
    .sg_en (mj_sg_en),
    .sga   (mj_sga),
    .bad   (sg_bad)
  );

  assign cfg_bad = act_start && (|cfg_cause);

  logic            ev_valid;
  cause_t          ev_cause;
  logic [CH_W-1:0] ev_ch;

  // Fixed precedence: activation, pointer, read fault, write fault
  always_comb begin
    ev_valid = 1'b1;
    ev_cause = '0;
    ev_ch    = '0;
    if (cfg_bad) begin
      ev_cause = cfg_cause;
      ev_ch    = act_ch;
    end else if (sg_bad) begin
      ev_cause[C_SGA] = 1'b1;
      ev_ch           = mj_ch;
    end else if (rd_berr) begin
      ev_cause[C_RDBUS] = 1'b1;
      ev_ch             = rd_ch;
    end else if (wr_berr) begin
      ev_cause[C_WRBUS] = 1'b1;
      ev_ch             = wr_ch;
    end else begin
      ev_valid = 1'b0;
    end
  end

  cause_t flags_q;

  dma_err_rec #(.CH_W(CH_W)) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_cause  (ev_cause),
    .ev_ch     (ev_ch),
    .clr       (err_clr),
    .err_valid (err_valid),
    .err_any   (err_any),
    .err_flags (flags_q),
    .err_chan  (err_chan)
  );

  assign err_flags = flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) go_ok <= 1'b0;
    else        go_ok <= act_start && !(|cfg_cause);
  end
endmodule

// File: rtl/dma_desc_checker_sva.sv
module dma_desc_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       act_start,
  input logic       err_clr,
  input logic       go_ok,
  input logic       err_valid,
  input logic       err_any,
  input logic [6:0] err_flags
);
  AST_GO_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    go_ok |-> $past(act_start)); // R6
  AST_GO_NO_CFG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (go_ok && err_valid) |-> (err_flags[3:0] == 4'b0)); // R11
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_flags != 7'b0 && err_any)); // R9
  AST_LATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> ($countones(err_flags[6:4]) <= 1)); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_clr) && !err_valid) |-> (err_flags == 7'b0 && !err_any)); // R10
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_valid && !$past(err_clr)) |-> $stable(err_flags)); // R12
endmodule

bind dma_desc_checker dma_desc_checker_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .act_start (act_start),
  .err_clr   (err_clr),
  .go_ok     (go_ok),
  .err_valid (err_valid),
  .err_any   (err_any),
  .err_flags (err_flags)
);

// File: tb/dma_desc_checker_tb_top.sv
module dma_desc_checker_tb_top;
  localparam int NCH = 8;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          act_start, act_citer_lk, act_biter_lk;
  logic [CW-1:0] act_ch, mj_ch, rd_ch, wr_ch;
  logic [2:0]    act_ssize, act_dsize;
  logic [15:0]   act_soff, act_doff;
  logic [31:0]   act_daddr, act_nbytes, mj_sga;
  logic [14:0]   act_citer;
  logic          mj_done, mj_sg_en, rd_berr, wr_berr, err_clr;
  logic          go_ok, err_valid, err_any;
  logic [CW-1:0] err_chan;
  logic [6:0]    err_flags;

  int checks = 0;
  int fails  = 0;

  dma_desc_checker #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .act_start(act_start), .act_ch(act_ch),
    .act_ssize(act_ssize), .act_dsize(act_dsize),
    .act_soff(act_soff), .act_daddr(act_daddr), .act_doff(act_doff),
    .act_nbytes(act_nbytes), .act_citer(act_citer),
    .act_citer_lk(act_citer_lk), .act_biter_lk(act_biter_lk),
    .mj_done(mj_done), .mj_ch(mj_ch), .mj_sg_en(mj_sg_en), .mj_sga(mj_sga),
    .rd_berr(rd_berr), .rd_ch(rd_ch), .wr_berr(wr_berr), .wr_ch(wr_ch),
    .err_clr(err_clr),
    .go_ok(go_ok), .err_valid(err_valid), .err_chan(err_chan),
    .err_any(err_any), .err_flags(err_flags)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic good_desc();
    act_ssize = 3'd2; act_dsize = 3'd2;
    act_soff = 16'd4; act_doff = 16'd4;
    act_daddr = 32'h1000; act_nbytes = 32'd16;
    act_citer = 15'd5; act_citer_lk = 1'b0; act_biter_lk = 1'b0;
  endtask

  task automatic quiet();
    act_start = 0; mj_done = 0; rd_berr = 0; wr_berr = 0; err_clr = 0;
  endtask

  // Advance one edge and sample 5 ns after it
  task automatic step();
    @(posedge clk);
    #5;
    quiet();
  endtask

  task automatic act_expect_err(string req, logic [CW-1:0] ch, logic [6:0] exp);
    act_ch = ch; act_start = 1;
    step();
    check(req, "err_valid", err_valid, 1);
    check(req, "go_ok", go_ok, 0);
    check(req, "flags", err_flags, exp);
    check(req, "chan", err_chan, ch);
    good_desc();
  endtask

  task automatic t_reset();
    check("R1", "go_ok", go_ok, 0);
    check("R1", "err_valid", err_valid, 0);
    check("R1", "err_any", err_any, 0);
    check("R1", "flags", err_flags, 0);
    check("R1", "chan", err_chan, 0);
  endtask

  task automatic t_good();
    good_desc(); act_ch = 3; act_start = 1;
    step();
    check("R6", "go_ok", go_ok, 1);
    check("R6", "err_valid", err_valid, 0);
    step();
    check("R6", "go_ok one cycle", go_ok, 0);
  endtask

  task automatic t_src_off();
    good_desc(); act_soff = 16'd6;
    act_expect_err("R2", 5, 7'b0000001);
    step();
    check("R6", "pulse ends", err_valid, 0);
    check("R12", "flags hold", err_flags, 7'b0000001);
    // 32-byte size class
    act_ssize = 3'd4; act_dsize = 3'd4; act_soff = 16'd32; act_doff = 16'd32;
    act_daddr = 32'h1040; act_nbytes = 32'd64; act_ch = 1; act_start = 1;
    step();
    check("R2", "size32 ok", go_ok, 1);
    act_ssize = 3'd4; act_dsize = 3'd4; act_soff = 16'd48; act_doff = 16'd32;
    act_daddr = 32'h1040; act_nbytes = 32'd64;
    act_expect_err("R2", 2, 7'b0000001);
    act_soff = 16'hfffc; act_ch = 4; act_start = 1;
    step();
    check("R2", "negative offset ok", go_ok, 1);
    act_ssize = 3'd5;
    act_expect_err("R2", 6, 7'b0000001);
  endtask

  task automatic t_dst();
    act_dsize = 3'd3; act_daddr = 32'h1004; act_doff = 16'd8;
    act_expect_err("R3", 1, 7'b0000010);
    act_dsize = 3'd6;
    act_expect_err("R3", 7, 7'b0000010);
    act_dsize = 3'd1; act_doff = 16'd3;
    act_expect_err("R4", 2, 7'b0000100);
    act_dsize = 3'd1; act_daddr = 32'h1001; act_doff = 16'd3;
    act_expect_err("R9", 3, 7'b0000110);
  endtask

  task automatic t_nbiter();
    act_ssize = 3'd0; act_soff = 16'd1; act_nbytes = 32'd6;
    act_expect_err("R5", 4, 7'b0001000);
    act_citer = 15'd0;
    act_expect_err("R5", 5, 7'b0001000);
    act_biter_lk = 1'b1;
    act_expect_err("R5", 6, 7'b0001000);
    act_citer_lk = 1'b1; act_biter_lk = 1'b1; act_ch = 0; act_start = 1;
    step();
    check("R5", "matched links ok", go_ok, 1);
  endtask

  task automatic t_sg();
    err_clr = 1;
    step();
    mj_done = 1; mj_ch = 2; mj_sg_en = 1; mj_sga = 32'h40;
    step();
    check("R7", "aligned no err", err_valid, 0);
    mj_done = 1; mj_ch = 2; mj_sg_en = 0; mj_sga = 32'h48;
    step();
    check("R7", "disabled no err", err_valid, 0);
    check("R7", "disabled no record", err_any, 0);
    mj_done = 1; mj_ch = 5; mj_sg_en = 1; mj_sga = 32'h48;
    step();
    check("R7", "err_valid", err_valid, 1);
    check("R7", "flags", err_flags, 7'b0010000);
    check("R7", "chan", err_chan, 5);
  endtask

  task automatic t_bus();
    rd_berr = 1; rd_ch = 2;
    step();
    check("R8", "rd flags", err_flags, 7'b0100000);
    check("R9", "rd chan", err_chan, 2);
    wr_berr = 1; wr_ch = 6;
    step();
    check("R8", "wr flags", err_flags, 7'b1000000);
    check("R9", "wr chan", err_chan, 6);
  endtask

  task automatic t_clear();
    err_clr = 1;
    step();
    check("R10", "flags cleared", err_flags, 0);
    check("R10", "any cleared", err_any, 0);
    err_clr = 1; rd_berr = 1; rd_ch = 1;
    step();
    check("R10", "error wins flags", err_flags, 7'b0100000);
    check("R10", "error wins any", err_any, 1);
  endtask

  task automatic t_prio();
    good_desc(); act_soff = 16'd2; act_ch = 3; act_start = 1;
    mj_done = 1; mj_sg_en = 1; mj_sga = 32'h4; mj_ch = 4;
    rd_berr = 1; rd_ch = 5; wr_berr = 1; wr_ch = 6;
    step();
    check("R11", "act wins", err_flags, 7'b0000001);
    check("R11", "act chan", err_chan, 3);
    good_desc();
    mj_done = 1; mj_sg_en = 1; mj_sga = 32'h4; mj_ch = 4;
    rd_berr = 1; rd_ch = 5; wr_berr = 1; wr_ch = 6;
    step();
    check("R11", "sg wins", err_flags, 7'b0010000);
    check("R11", "sg chan", err_chan, 4);
    rd_berr = 1; rd_ch = 5; wr_berr = 1; wr_ch = 6;
    act_ch = 1; act_start = 1;
    step();
    check("R11", "rd wins", err_flags, 7'b0100000);
    check("R11", "rd chan", err_chan, 5);
    check("R11", "good act still goes", go_ok, 1);
  endtask

  initial begin
    quiet(); good_desc();
    act_ch = 0; mj_ch = 0; rd_ch = 0; wr_ch = 0; mj_sg_en = 0; mj_sga = 0;
    repeat (3) @(posedge clk);
    #5;
    rst_n = 1;
    t_reset();
    t_good();
    t_src_off();
    t_dst();
    t_nbiter();
    t_sg();
    t_bus();
    t_clear();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule